// File: doc/BRIEF.md
# Serial MII Segment Gasket

This block sits on the MAC side of a serial MII link and turns the parallel transmit and receive signals of one 10/100 MAC port into single-wire streams. Control and data share the wire in fixed ten-bit segments. The block generates the SYNC strobe that delimits those segments, and one bit crosses the wire on each reference clock.

On the transmit side, the MAC's enable, error and data byte are sampled once per segment. They are then shifted out starting with the error bit. On the receive side, the incoming wire is framed by a SYNC strobe that returns together with it. The carrier-sense flag, data-valid flag and data byte of each complete segment are presented at once, marked by a one-cycle valid strobe.

Several ports may share one SYNC and clock pair, each port with its own pair of data lines. Speed adaptation, multi-port muxing and any framing above the segment level are left to other logic.

Top module: `sermii_gasket`

## Requirements
- R1: `seg_sync_o` is high for exactly one clock in every ten. The first high cycle is the first cycle after reset is released.
- R2: Transmit segment layout is error bit in bit 0, enable in bit 1, and data bit i in bit 2+i. Bit 0 appears on `seg_tx_o` in the cycle where `seg_sync_o` is high, and each following clock shows the next bit.
- R3: Transmit inputs are sampled only at the clock edge that starts a SYNC cycle. Changes at any other time do not alter the segment being sent.
- R4: An idle MAC (enable, error and data all 0 at the sampling edge) produces an all-zero segment.
- R5: Receive segment layout is carrier sense in bit 0, data-valid in bit 1, and data bit i in bit 2+i. Bit 0 is the line value captured at the edge where `seg_rx_sync_i` is high.
- R6: `mac_rx_valid_o` is high for one cycle, the cycle after the edge that captures the tenth bit. The receive outputs hold their value at all other times.
- R7: A receive SYNC that arrives before ten bits have been gathered discards the partial segment and restarts counting at bit 0.
- R8: Line bits received when no segment has been opened by a receive SYNC produce no valid strobe and leave the outputs unchanged.
- R9: While `rst_n` is low, `seg_sync_o`, `seg_tx_o`, `mac_rx_valid_o` and the receive outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mac_tx_en_i | input | 1 | MAC transmit enable |
| mac_tx_er_i | input | 1 | MAC transmit error |
| mac_txd_i | input | DATA_W | MAC transmit byte |
| seg_sync_o | output | 1 | Segment start strobe |
| seg_tx_o | output | 1 | Serial transmit line |
| seg_rx_i | input | 1 | Serial receive line |
| seg_rx_sync_i | input | 1 | SYNC as it arrives alongside the receive line |
| mac_crs_o | output | 1 | Received carrier sense |
| mac_rx_dv_o | output | 1 | Received data-valid |
| mac_rxd_o | output | DATA_W | Received byte |
| mac_rx_valid_o | output | 1 | One-cycle strobe for a fresh received segment |

## Verification
The MAC inputs are sampled at the edge that opens a SYNC cycle. Bit k of that segment is on the transmit line k cycles into the segment. In the loop-back bench, the receive wire and its SYNC each pass through one register, so the valid strobe is due eleven cycles after the SYNC that opened the segment. That is the cycle just after the next SYNC.

The bench counts the cycles since each SYNC at the falling edge. It reads the ten transmit bits at positions 0 to 9, and it expects the valid strobe at position 1 and at no other position. For the directly driven receive cases, the strobe is expected at the falling edge that follows the edge capturing the tenth bit.

// File: rtl/sermii_pkg.sv
// Shared constants for the serial MII gasket.
// Assumes a segment carries two control bits ahead of the data byte.
package sermii_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CTRL_W = 2;

    // Segment length for a given data width.
    function automatic int unsigned seg_len(input int unsigned data_w);
        return data_w + CTRL_W;
    endfunction
endpackage

// File: rtl/sermii_seg_timer.sv
// Free-running segment timer.
// Produces the registered SYNC strobe and a load pulse in the cycle just
// before SYNC, so the transmitter samples on the edge that opens a segment.
// Assumes SEG_LEN >= 2.
module sermii_seg_timer #(
    parameter int unsigned SEG_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic sync_o,
    output logic load_o
);
    localparam int unsigned CW   = $clog2(SEG_LEN);
    localparam logic [CW-1:0] LAST = CW'(SEG_LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          sync_q;

    // Count bit slots and raise SYNC on the slot after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= LAST;
            sync_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            sync_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            sync_q <= 1'b0;
        end
    end

    assign sync_o = sync_q;
    assign load_o = (cnt_q == LAST);
endmodule

// File: rtl/sermii_seg_tx.sv
// Transmit serializer.
// On load_i it captures error, enable and data as one coherent word and
// then shifts it out LSB first: error, enable, data bit 0 upward.
// Assumes load_i recurs every segment length.
module sermii_seg_tx #(
    parameter int unsigned DATA_W = sermii_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              tx_en_i,
    input  logic              tx_er_i,
    input  logic [DATA_W-1:0] txd_i,
    output logic              line_o
);
    localparam int unsigned SEG_LEN = sermii_pkg::seg_len(DATA_W);

    logic [SEG_LEN-1:0] shift_q;

    // Load a fresh segment or move the current one by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (load_i) begin
            shift_q <= {txd_i, tx_en_i, tx_er_i};
        end else begin
            shift_q <= {1'b0, shift_q[SEG_LEN-1:1]};
        end
    end

    assign line_o = shift_q[0];
endmodule

// File: rtl/sermii_seg_rx.sv
// Receive deserializer.
// A high sync_i opens a segment with the bit captured on the same edge.
// Each later edge fills the next slot. When the last bit arrives, the whole
// segment is published with a one-cycle valid. A sync_i seen mid-segment
// restarts the count, and bits outside an open segment are dropped.
module sermii_seg_rx #(
    parameter int unsigned DATA_W = sermii_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic              line_i,
    output logic              crs_o,
    output logic              dv_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int unsigned SEG_LEN = sermii_pkg::seg_len(DATA_W);
    localparam int unsigned CW      = $clog2(SEG_LEN);
    localparam logic [CW-1:0] LAST  = CW'(SEG_LEN - 1);

    logic [CW-1:0]      cnt_q;
    logic [SEG_LEN-2:0] slot_w;
    logic               last_w;

    assign last_w = !sync_i && (cnt_q == LAST);

    // Track how many bits of the open segment are stored (0 = none open).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sync_i) begin
            cnt_q <= CW'(1);
        end else if (last_w) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One storage flop per slot except the last, which goes straight out.
    for (genvar k = 0; k < SEG_LEN - 1; k++) begin : g_slot
        logic bit_q;
        if (k == 0) begin : g_head
            // The opening bit is taken on the SYNC edge.
            always_ff @(posedge clk) begin
                if (!rst_n)      bit_q <= 1'b0;
                else if (sync_i) bit_q <= line_i;
            end
        end else begin : g_body
            // Later bits are taken when the count points at this slot.
            always_ff @(posedge clk) begin
                if (!rst_n)                                bit_q <= 1'b0;
                else if (!sync_i && cnt_q == CW'(k))       bit_q <= line_i;
            end
        end
        assign slot_w[k] = bit_q;
    end

    // Publish a complete segment and pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            crs_o   <= 1'b0;
            dv_o    <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= last_w;
            if (last_w) begin
                {data_o, dv_o, crs_o} <= {line_i, slot_w};
            end
        end
    end
endmodule

// File: rtl/sermii_gasket.sv
// Serial MII gasket for one MAC port.
// Combines the segment timer, the transmit serializer and the receive
// deserializer. The receiver is framed by seg_rx_sync_i, which is the shared
// SYNC after the same path as seg_rx_i.
module sermii_gasket #(
    parameter int unsigned DATA_W = sermii_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_tx_en_i,
    input  logic              mac_tx_er_i,
    input  logic [DATA_W-1:0] mac_txd_i,
    output logic              seg_sync_o,
    output logic              seg_tx_o,
    input  logic              seg_rx_i,
    input  logic              seg_rx_sync_i,
    output logic              mac_crs_o,
    output logic              mac_rx_dv_o,
    output logic [DATA_W-1:0] mac_rxd_o,
    output logic              mac_rx_valid_o
);
    localparam int unsigned SEG_LEN = sermii_pkg::seg_len(DATA_W);

    logic load_w;

    sermii_seg_timer #(.SEG_LEN(SEG_LEN)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_o (seg_sync_o),
        .load_o (load_w)
    );

    sermii_seg_tx #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .tx_en_i (mac_tx_en_i),
        .tx_er_i (mac_tx_er_i),
        .txd_i   (mac_txd_i),
        .line_o  (seg_tx_o)
    );

    sermii_seg_rx #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (seg_rx_sync_i),
        .line_i  (seg_rx_i),
        .crs_o   (mac_crs_o),
        .dv_o    (mac_rx_dv_o),
        .data_o  (mac_rxd_o),
        .valid_o (mac_rx_valid_o)
    );
endmodule

// File: rtl/sermii_gasket_chk.sv
// Property checker for the serial MII gasket, bound to every instance.
// It keeps its own counters of cycles since SYNC and of receive bits since
// the receive SYNC, so no window depends on a large delay.
module sermii_gasket_chk #(
    parameter int unsigned DATA_W = sermii_pkg::BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync,
    input logic              tx,
    input logic              tx_er,
    input logic              rx_sync,
    input logic              valid,
    input logic              crs,
    input logic              dv,
    input logic [DATA_W-1:0] rxd
);
    localparam int unsigned SEG_LEN = sermii_pkg::seg_len(DATA_W);
    localparam int unsigned CW      = $clog2(SEG_LEN + 1);
    localparam logic [CW-1:0] FULL  = CW'(SEG_LEN);
    localparam logic [CW-1:0] LAST  = CW'(SEG_LEN - 1);

    logic [CW-1:0] since_q;
    logic          seen_q;
    logic [CW-1:0] bits_q;

    // Cycles since the last SYNC, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (sync) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != FULL) begin
            since_q <= since_q + 1'b1;
        end
    end

    // Receive bits gathered since the last receive SYNC.
    always_ff @(posedge clk) begin
        if (!rst_n)              bits_q <= '0;
        else if (rx_sync)        bits_q <= CW'(1);
        else if (bits_q == FULL) bits_q <= '0;
        else if (bits_q != '0)   bits_q <= bits_q + 1'b1;
    end

    // R1
    sync_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && seen_q) |-> since_q == LAST);
    // R1
    sync_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && since_q == LAST) |-> sync);
    // R2
    tx_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> tx == $past(tx_er));
    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R7
    valid_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> bits_q == FULL);
    // R7
    span_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q == FULL |-> valid);
    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable({rxd, dv, crs}));
endmodule

bind sermii_gasket sermii_gasket_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync    (seg_sync_o),
    .tx      (seg_tx_o),
    .tx_er   (mac_tx_er_i),
    .rx_sync (seg_rx_sync_i),
    .valid   (mac_rx_valid_o),
    .crs     (mac_crs_o),
    .dv      (mac_rx_dv_o),
    .rxd     (mac_rxd_o)
);

// File: tb/sermii_gasket_bench.sv
`timescale 1ns/1ps
module sermii_gasket_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, tx_er = 1'b0;
    logic [7:0] txd = 8'h00;
    logic       inject = 1'b0, inj_line = 1'b0, inj_sync = 1'b0;
    logic       lb_line, lb_sync;
    logic       sync_w, tx_w, crs_w, dv_w, valid_w;
    logic [7:0] rxd_w;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    // One-bit-delay loop-back: line and SYNC each pass through one flop.
    always_ff @(posedge clk) begin
        lb_line <= tx_w;
        lb_sync <= sync_w;
    end

    sermii_gasket u_sermii_gasket (
        .clk            (clk),
        .rst_n          (rst_n),
        .mac_tx_en_i    (tx_en),
        .mac_tx_er_i    (tx_er),
        .mac_txd_i      (txd),
        .seg_sync_o     (sync_w),
        .seg_tx_o       (tx_w),
        .seg_rx_i       (inject ? inj_line : lb_line),
        .seg_rx_sync_i  (inject ? inj_sync : lb_sync),
        .mac_crs_o      (crs_w),
        .mac_rx_dv_o    (dv_w),
        .mac_rxd_o      (rxd_w),
        .mac_rx_valid_o (valid_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Segment word: bit0 error/crs, bit1 enable/dv, bits 2..9 data.
    function automatic logic [9:0] seg_word(input logic en, input logic er, input logic [7:0] d);
        return {d, en, er};
    endfunction

    // Directed segments first, then random ones.
    function automatic logic [9:0] pick(input int n);
        if (n < 3)   return 10'h000;
        if (n == 3)  return seg_word(1'b0, 1'b1, 8'h00);
        if (n == 4)  return seg_word(1'b1, 1'b0, 8'h00);
        if (n < 13)  return 10'(1) << (n - 3);
        if (n == 13) return 10'h3FF;
        return 10'($urandom);
    endfunction

    task automatic apply(input logic [9:0] w);
        {txd, tx_en, tx_er} = w;
    endtask

    logic [9:0] got;
    int vcount;

    task automatic inj_bit(input logic s, input logic d);
        inj_sync = s;
        inj_line = d;
        @(negedge clk);
        if (valid_w) begin
            vcount++;
            got = {rxd_w, dv_w, crs_w};
        end
    endtask

    initial begin : main
        logic [9:0] exp_q[$];
        bit         junk_q[$];
        logic [9:0] txbits, cur, pa, pb, pc;
        int tx_idx, rx_idx, pos, syncs, last_sync, nseg;
        bit junky;
        void'($urandom(32'h5EED_0042));
        tx_idx = 0; rx_idx = 0; pos = 0; syncs = 0; last_sync = 0; nseg = 0;
        junky = 1'b0; cur = '0; txbits = '0;

        // Reset state.
        repeat (4) @(negedge clk);
        chk("R9 sync", 32'(sync_w), 0);
        chk("R9 tx", 32'(tx_w), 0);
        chk("R9 valid", 32'(valid_w), 0);
        chk("R9 rx outputs", 32'({rxd_w, dv_w, crs_w}), 0);

        exp_q.push_back(10'h000);
        junk_q.push_back(1'b0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (sync_w) begin
                if (syncs > 0) chk("R1 period", 32'(cyc - last_sync), 10);
                else           chk("R1 first sync", 32'(cyc), 0);
                last_sync = cyc;
                syncs++;
                pos = 0;
            end else begin
                pos++;
            end
            if (syncs == 0) chk("R1 no early sync", 1, 0);

            // Transmit line: bit pos of the segment latched at the last SYNC.
            if (pos <= 9) begin
                txbits[pos] = tx_w;
                if (pos == 9) begin
                    if (junk_q[tx_idx])
                        chk("R3 segment", 32'(txbits), 32'(exp_q[tx_idx]));
                    else if (exp_q[tx_idx] == 10'h000)
                        chk("R4 idle", 32'(txbits), 0);
                    else
                        chk("R2 segment", 32'(txbits), 32'(exp_q[tx_idx]));
                    tx_idx++;
                end
            end

            // Receive side: strobe due at position 1 from the second SYNC on.
            chk("R6 strobe timing", 32'(valid_w), 32'(pos == 1 && syncs >= 2));
            if (valid_w) begin
                chk("R5 received", 32'({rxd_w, dv_w, crs_w}), 32'(exp_q[rx_idx]));
                rx_idx++;
            end

            // Stimulus for the segment sampled at the next SYNC edge.
            if (sync_w) begin
                cur   = pick(nseg);
                junky = (nseg >= 14) && (nseg[0] == 1'b1);
                exp_q.push_back(cur);
                junk_q.push_back(junky);
                apply(cur);
                nseg++;
            end else if (junky && pos >= 2 && pos <= 6) begin
                apply(10'($urandom));
            end else if (junky && pos == 7) begin
                apply(cur);
            end
        end

        // Drive the receiver directly.
        inject = 1'b1;
        inj_line = 1'b0;
        inj_sync = 1'b0;
        repeat (15) @(negedge clk);

        // R7: a 4-bit partial segment, then a full one.
        pa = 10'h2A5; pb = 10'h15B; vcount = 0; got = '0;
        for (int k = 0; k < 4; k++)  inj_bit(k == 0, pa[k]);
        for (int k = 0; k < 10; k++) inj_bit(k == 0, pb[k]);
        chk("R7 strobe after bit 10", 32'(vcount), 1);
        for (int k = 0; k < 3; k++)  inj_bit(1'b0, 1'b0);
        chk("R7 one strobe", 32'(vcount), 1);
        chk("R7 restart value", 32'(got), 32'(pb));

        // R7: SYNC lands in the tenth slot of a partial segment.
        pb = 10'h0F3; vcount = 0;
        for (int k = 0; k < 9; k++)  inj_bit(k == 0, pa[k]);
        chk("R7 no strobe for partial", 32'(vcount), 0);
        for (int k = 0; k < 10; k++) inj_bit(k == 0, pb[k]);
        for (int k = 0; k < 3; k++)  inj_bit(1'b0, 1'b0);
        chk("R7 late restart strobe", 32'(vcount), 1);
        chk("R7 late restart value", 32'(got), 32'(pb));

        // R8: bits without a SYNC are ignored and outputs hold.
        pc = 10'h3C6; vcount = 0;
        for (int k = 0; k < 10; k++) inj_bit(1'b0, pc[k]);
        for (int k = 0; k < 3; k++)  inj_bit(1'b0, 1'b1);
        chk("R8 no strobe", 32'(vcount), 0);
        chk("R8 outputs held", 32'({rxd_w, dv_w, crs_w}), 32'(pb));

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule